// File: doc/BRIEF.md
# Dual-Port Circular Mailbox Buffer

This block carries 32-bit words between a host and an embedded peer processor through two independent ring buffers, one for each direction. Each side sees the same four-word register window. The window has a transmit data port, its own control/status word, a receive data port and a read-only view of the opposite side's status word. Each status word reports, for the ring that its owner writes, a free-running 8-bit write pointer, a free-running 8-bit read pointer and the ring depth in slots. Software finds the fill level as `(wp - rp) mod 256` and the free space as `depth - fill`.

Each status word also carries an interrupt enable, an interrupt status, an interrupt-generate strobe, a ready flag, a reset request and two sticky error flags. Writing the generate bit raises interrupt status on the opposite side. A reset request from either side clears both rings and holds them empty, and the requester's ready flag reads 0 while the request stands. The side leaves reset with one status write that drops the reset bit and sets ready and generate.

The data windows have no valid/ready back-pressure. Every access strobe completes in one cycle. A write into a full ring and a read from an empty ring are dropped and leave a sticky error flag, so software is expected to poll the pointers first. Reads return data combinationally in the strobe cycle. Pointers and flags change at the clock edge that ends the strobe.

Top module: `mbox_dual`

## Requirements
- R1: After reset both status words read `DEPTH` in bits 31:24 and zero in every other bit, and both interrupt outputs are low.
- R2: A write to word 0 (byte 0x00) that is accepted advances the writer's status write pointer (bits 23:16) by one. The receiving side reads the words from its word 2 (byte 0x08) in the order they were written, and each read advances the read pointer (bits 15:8) in the writer's status word by one.
- R3: While the fill level `(wp - rp) mod 256` equals `DEPTH`, a data write is dropped and the write pointer does not move. The writer's overflow flag (status bit 5) is then set; it stays set until a 1 is written to bit 5.
- R4: A read of word 2 while the ring it reads is empty returns 0 and leaves the pointers unchanged. The reader's underflow flag (status bit 6) is then set; it stays set until a 1 is written to bit 6.
- R5: The pointers are free-running 8-bit counters that wrap from 255 to 0, and data order holds across both the pointer wrap and the storage wrap.
- R6: Writing a 1 to status bit 2 (generate) sets interrupt status (bit 1) in the opposite side's status word. Bit 2 always reads back 0. A side's interrupt output is high exactly when its bits 0 (enable) and 1 (status) are both set.
- R7: Interrupt status is cleared only by writing a 1 to bit 1; writing 0 to it has no effect.
- R8: While either side's reset bit (bit 4) is set, both rings' pointers are zero and data writes and reads are ignored, and the requester's ready bit (bit 3) reads 0 even if written as 1.
- R9: A status write with bit 4 clear and bits 3 and 2 set takes the side out of reset with ready set, and it interrupts the opposite side.
- R10: The peer-to-host direction behaves the same as the host-to-peer direction: the peer writes its word 0, the host reads its word 2, and the peer status word holds that ring's pointers.
- R11: Writes to word 3, to the pointer and depth fields, and reads of word 0 have no effect; word 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host word offset (byte offset / 4) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid in the strobe cycle |
| h_irq | output | 1 | Interrupt toward the host |
| p_wr | input | 1 | Peer write strobe |
| p_rd | input | 1 | Peer read strobe |
| p_addr | input | 2 | Peer word offset (byte offset / 4) |
| p_wdata | input | 32 | Peer write data |
| p_rdata | output | 32 | Peer read data, valid in the strobe cycle |
| p_irq | output | 1 | Interrupt toward the peer |

## Verification
Three transfer patterns are used. A long single-word ping-pong runs past the 8-bit pointer wrap and separates pointer arithmetic from storage indexing. A fill-then-drain sweep over every level from 1 to the depth catches ordering and fill-count errors. An overfill by one word shows whether the extra word is dropped or overwrites the oldest entry. Empty reads, generate/clear sequences with the enable on and off, and the reset entry/exit sequence check that interrupts cross to the correct side and that reset clears both rings and not just one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // word offsets inside each side's window
  localparam logic [1:0] W_TX    = 2'd0;
  localparam logic [1:0] W_STAT  = 2'd1;
  localparam logic [1:0] W_RX    = 2'd2;
  localparam logic [1:0] W_OTHER = 2'd3;

  // status bit positions
  localparam int B_IE  = 0;
  localparam int B_IS  = 1;
  localparam int B_IG  = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_OVF = 5;
  localparam int B_UDF = 6;
  localparam int CTRL_W = 7;

  typedef struct packed {
    logic ie;
    logic is;
    logic rdy;
    logic rst;
    logic ovf;
    logic udf;
  } ctl_t;

  function automatic logic [31:0] stat_word(input logic [7:0] depth,
                                            input logic [7:0] wp,
                                            input logic [7:0] rp,
                                            input ctl_t c);
    return {depth, wp, rp, 1'b0, c.udf, c.ovf, c.rst, c.rdy, 1'b0, c.is, c.ie};
  endfunction
endpackage

// File: rtl/mbox_ring.sv
module mbox_ring #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [7:0]    wp,
  output logic [7:0]    rp,
  output logic          full,
  output logic          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [7:0] D8 = 8'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wi, ri;
  logic [7:0]    fill;
  logic          do_push, do_pop;

  assign fill    = wp - rp;
  assign full    = (fill == D8);
  assign empty   = (fill == 8'd0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[ri];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      wi <= '0;
      ri <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
      wi <= '0;
      ri <= '0;
    end else begin
      if (do_push) begin
        wp <= wp + 8'd1;
        wi <= (wi == LAST) ? '0 : wi + 1'b1;
      end
      if (do_pop) begin
        rp <= rp + 8'd1;
        ri <= (ri == LAST) ? '0 : ri + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wi] <= wdata;
  end
endmodule

// File: rtl/mbox_ctl.sv
module mbox_ctl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic [CTRL_W-1:0] wbits,
  input  logic              set_is,
  input  logic              set_ovf,
  input  logic              set_udf,
  output ctl_t              ctl,
  output logic              ig
);
  assign ig = wr_stat & wbits[B_IG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr_stat) begin
        ctl.ie  <= wbits[B_IE];
        ctl.rst <= wbits[B_RST];
        ctl.rdy <= wbits[B_RDY] & ~wbits[B_RST];
      end
      if (set_is)                       ctl.is  <= 1'b1;
      else if (wr_stat && wbits[B_IS])  ctl.is  <= 1'b0;
      if (set_ovf)                      ctl.ovf <= 1'b1;
      else if (wr_stat && wbits[B_OVF]) ctl.ovf <= 1'b0;
      if (set_udf)                      ctl.udf <= 1'b1;
      else if (wr_stat && wbits[B_UDF]) ctl.udf <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_dual.sv
module mbox_dual
  import mbox_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [1:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  input  logic        p_wr,
  input  logic        p_rd,
  input  logic [1:0]  p_addr,
  input  logic [31:0] p_wdata,
  output logic [31:0] p_rdata,
  output logic        p_irq
);
  localparam logic [7:0] D8 = 8'(DEPTH);

  ctl_t        h_ctl, p_ctl;
  logic        h_ig, p_ig, h_rst, p_rst, h_rdy, p_is, clr;
  logic        h_push, h_pop, p_push, p_pop;
  logic [7:0]  h2p_wp, h2p_rp, p2h_wp, p2h_rp;
  logic        h2p_full, h2p_empty, p2h_full, p2h_empty;
  logic [31:0] h2p_head, p2h_head, h_stat, p_stat;

  assign h_rst  = h_ctl.rst;
  assign p_rst  = p_ctl.rst;
  assign h_rdy  = h_ctl.rdy;
  assign p_is   = p_ctl.is;
  assign clr    = h_rst | p_rst;

  assign h_push = h_wr & (h_addr == W_TX) & ~clr;
  assign h_pop  = h_rd & (h_addr == W_RX) & ~clr;
  assign p_push = p_wr & (p_addr == W_TX) & ~clr;
  assign p_pop  = p_rd & (p_addr == W_RX) & ~clr;

  mbox_ring #(.DEPTH(DEPTH), .DW(32)) u_h2p (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(h_push), .pop(p_pop),
    .wdata(h_wdata), .head(h2p_head), .wp(h2p_wp), .rp(h2p_rp),
    .full(h2p_full), .empty(h2p_empty));

  mbox_ring #(.DEPTH(DEPTH), .DW(32)) u_p2h (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(p_push), .pop(h_pop),
    .wdata(p_wdata), .head(p2h_head), .wp(p2h_wp), .rp(p2h_rp),
    .full(p2h_full), .empty(p2h_empty));

  mbox_ctl u_hctl (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(h_wr & (h_addr == W_STAT)), .wbits(h_wdata[CTRL_W-1:0]),
    .set_is(p_ig), .set_ovf(h_push & h2p_full), .set_udf(h_pop & p2h_empty),
    .ctl(h_ctl), .ig(h_ig));

  mbox_ctl u_pctl (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(p_wr & (p_addr == W_STAT)), .wbits(p_wdata[CTRL_W-1:0]),
    .set_is(h_ig), .set_ovf(p_push & p2h_full), .set_udf(p_pop & h2p_empty),
    .ctl(p_ctl), .ig(p_ig));

  assign h_stat = stat_word(D8, h2p_wp, h2p_rp, h_ctl);
  assign p_stat = stat_word(D8, p2h_wp, p2h_rp, p_ctl);

  always_comb begin
    unique case (h_addr)
      W_STAT:  h_rdata = h_stat;
      W_RX:    h_rdata = p2h_empty ? '0 : p2h_head;
      W_OTHER: h_rdata = p_stat;
      default: h_rdata = '0;
    endcase
    unique case (p_addr)
      W_STAT:  p_rdata = p_stat;
      W_RX:    p_rdata = h2p_empty ? '0 : h2p_head;
      W_OTHER: p_rdata = h_stat;
      default: p_rdata = '0;
    endcase
  end

  assign h_irq = h_ctl.ie & h_ctl.is;
  assign p_irq = p_ctl.ie & p_ctl.is;
endmodule

// File: rtl/mbox_dual_chk.sv
module mbox_dual_chk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       h_push,
  input logic       p_pop,
  input logic       h2p_full,
  input logic       h2p_empty,
  input logic [7:0] h2p_wp,
  input logic [7:0] h2p_rp,
  input logic [7:0] p2h_wp,
  input logic [7:0] p2h_rp,
  input logic       h_ig,
  input logic       p_is,
  input logic       h_rst,
  input logic       h_rdy
);
  localparam logic [7:0] D8 = 8'(DEPTH);
  logic [7:0] h2p_fill, p2h_fill;
  assign h2p_fill = h2p_wp - h2p_rp;
  assign p2h_fill = p2h_wp - p2h_rp;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (h2p_fill <= D8) && (p2h_fill <= D8));

  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (h_push && !h2p_full) |=> (h2p_wp == $past(h2p_wp) + 8'd1));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (h_push && h2p_full) |=> (h2p_wp == $past(h2p_wp)));

  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (p_pop && h2p_empty) |=> (h2p_rp == $past(h2p_rp)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (h2p_wp == 8'd0 && h2p_rp == 8'd0 && p2h_wp == 8'd0 && p2h_rp == 8'd0));

  a_r8_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    h_rst |-> !h_rdy);

  a_r6_cross_irq: assert property (@(posedge clk) disable iff (!rst_n)
    h_ig |=> p_is);
endmodule

bind mbox_dual mbox_dual_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/mbox_dual_bench.sv
module mbox_dual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 0, h_rd = 0, p_wr = 0, p_rd = 0;
  logic [1:0]  h_addr = 0, p_addr = 0;
  logic [31:0] h_wdata = 0, p_wdata = 0;
  logic [31:0] h_rdata, p_rdata;
  logic        h_irq, p_irq;

  int nchk = 0;
  int nbad = 0;

  mbox_dual #(.DEPTH(DEPTH)) u_mbox_dual (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] es(input logic [7:0] w, input logic [7:0] r,
                                     input logic [7:0] bits);
    return {8'(DEPTH), w, r, bits};
  endfunction

  function automatic logic [31:0] val(input int n);
    return (32'(n) * 32'h9E37_79B1) ^ 32'(n + 7);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask
  task automatic hr(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1; #1 d = h_rdata;
    @(negedge clk); h_rd = 1'b0;
  endtask
  task automatic pw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); p_addr = a; p_wdata = d; p_wr = 1'b1;
    @(negedge clk); p_wr = 1'b0;
  endtask
  task automatic pr(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); p_addr = a; p_rd = 1'b1; #1 d = p_rdata;
    @(negedge clk); p_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  hp, pp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hr(2'd1, d); chk("R1 host status", d, es(0, 0, 0));
    pr(2'd1, d); chk("R1 peer status", d, es(0, 0, 0));
    chk("R1 irqs", {30'd0, h_irq, p_irq}, 32'd0);

    // R2/R5 ping-pong past the pointer wrap
    for (int n = 0; n < 300; n++) begin
      hw(2'd0, val(n));
      pr(2'd2, d); chk("R2 order", d, val(n));
      hr(2'd1, d); chk("R5 wrap ptrs", d, es(8'(n + 1), 8'(n + 1), 0));
    end
    hp = 8'(300);

    // R2 fill-level sweep
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) hw(2'd0, val(1000 + i));
      hr(2'd1, d); chk("R2 fill", d, es(hp + 8'(k), hp, 0));
      for (int i = 0; i < k; i++) begin
        pr(2'd2, d); chk("R2 drain", d, val(1000 + i));
      end
      hp = hp + 8'(k);
    end

    // R3 overfill by one
    for (int i = 0; i <= DEPTH; i++) hw(2'd0, val(2000 + i));
    hr(2'd1, d); chk("R3 full drop", d, es(hp + 8'(DEPTH), hp, 8'h20));
    for (int i = 0; i < DEPTH; i++) begin
      pr(2'd2, d); chk("R3 kept words", d, val(2000 + i));
    end
    hp = hp + 8'(DEPTH);
    hr(2'd1, d); chk("R3 ovf sticky", d, es(hp, hp, 8'h20));
    hw(2'd1, 32'h20);
    hr(2'd1, d); chk("R3 ovf w1c", d, es(hp, hp, 0));

    // R4 empty read
    pr(2'd2, d); chk("R4 empty data", d, 0);
    hr(2'd1, d); chk("R4 ptr hold", d, es(hp, hp, 0));
    pr(2'd1, d); chk("R4 udf flag", d, es(0, 0, 8'h40));
    pw(2'd1, 32'h40);
    pr(2'd1, d); chk("R4 udf w1c", d, es(0, 0, 0));

    // R10 peer to host
    for (int i = 0; i < 3; i++) pw(2'd0, val(3000 + i));
    hr(2'd3, d); chk("R10 peer fill", d, es(3, 0, 0));
    for (int i = 0; i < 3; i++) begin
      hr(2'd2, d); chk("R10 order", d, val(3000 + i));
    end
    pp = 8'd3;
    hr(2'd2, d); chk("R10 empty data", d, 0);
    hr(2'd1, d); chk("R10 host udf", d, es(hp, hp, 8'h40));
    hw(2'd1, 32'h40);

    // R6/R7 interrupts
    pw(2'd1, 32'h1);
    hw(2'd1, 32'h4);
    chk("R6 peer irq", {31'd0, p_irq}, 1);
    pr(2'd1, d); chk("R6 peer is", d, es(pp, pp, 8'h03));
    hr(2'd1, d); chk("R6 ig not sticky", d, es(hp, hp, 0));
    pw(2'd1, 32'h1);
    chk("R7 write0 keeps", {31'd0, p_irq}, 1);
    pw(2'd1, 32'h3);
    chk("R7 w1c clears", {31'd0, p_irq}, 0);
    hw(2'd1, 32'h1);
    pw(2'd1, 32'h5);
    chk("R6 host irq", {31'd0, h_irq}, 1);
    hw(2'd1, 32'h2);
    chk("R6 irq needs enable", {31'd0, h_irq}, 0);
    hr(2'd1, d); chk("R6 host cleared", d, es(hp, hp, 0));

    // R11 ignored writes and reads
    pr(2'd1, d);
    hw(2'd3, 32'hFFFF_FFFF);
    pr(2'd1, d); chk("R11 word3 write", d, es(pp, pp, 8'h01));
    hw(2'd1, 32'h00FF_FF00);
    hr(2'd1, d); chk("R11 ptr fields", d, es(hp, hp, 0));
    hr(2'd0, d); chk("R11 word0 read", d, 0);

    // R8 reset request
    hw(2'd1, 32'h8);
    hr(2'd1, d); chk("R8 ready set", d, es(hp, hp, 8'h08));
    hw(2'd0, 32'hA5A5_0001);
    hw(2'd0, 32'hA5A5_0002);
    pw(2'd0, 32'h5A5A_0003);
    hw(2'd1, 32'h1C);
    hr(2'd1, d); chk("R8 cleared not ready", d, es(0, 0, 8'h10));
    pr(2'd1, d); chk("R8 peer ring cleared", d, es(0, 0, 8'h03));
    hw(2'd0, 32'hDEAD_BEEF);
    pr(2'd2, d); chk("R8 data ignored", d, 0);
    hr(2'd1, d); chk("R8 ptrs stay zero", d, es(0, 0, 8'h10));

    // R9 leave reset
    pw(2'd1, 32'h3);
    hw(2'd1, 32'h0C);
    hr(2'd1, d); chk("R9 ready back", d, es(0, 0, 8'h08));
    chk("R9 peer irq", {31'd0, p_irq}, 1);
    hw(2'd0, 32'h1234_5678);
    pr(2'd2, d); chk("R9 transfer resumes", d, 32'h1234_5678);
    hr(2'd1, d); chk("R9 ptrs", d, es(1, 1, 8'h08));

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule